// File: doc/BRIEF.md
# Pipelined Control Decode and Staging

This block sits beside the decode stage of a five-stage in-order processor. It turns the 6-bit major opcode of the instruction being decoded into a nine-line control word. It then carries that word down the pipeline in step with the instruction. The fetch and decode stages need no decoded controls, because instruction fetch, program-counter update and register reads are always enabled. Every line is therefore produced in decode and consumed later.

The control word is split into three groups:

- The **execute group**: destination-field select, a two-bit ALU operation class and the ALU second-operand select.
- The **memory group**: branch-equal, data read and data write.
- The **write-back group**: register write enable and write-back source select.

The first pipeline register holds all nine lines. The second holds only the memory and write-back groups. The third holds only the write-back group, so each group is dropped once its stage has used it. A bubble request zeroes the whole word as it enters the first register, which turns the slot into a no-op. The block has no data stream, so all of its pins are plain control pins with no valid/ready handshake. It never applies back-pressure.

Top module: `pipe_ctl_top`

## Requirements
- R1: A synchronous active-high reset clears all three stage registers, so every output reads 0 in the cycle after a reset edge, whatever the opcode.
- R2: The execute group reflects the opcode sampled at the previous rising edge. The memory group reflects it two edges later, and the write-back group three edges later.
- R3: Opcode 0x00 (register format) gives dst_rd=1, alu_op=2'b10, alu_imm=0, all memory lines 0, reg_we=1 and wb_mem=0.
- R4: Opcode 0x23 (load) gives dst_rd=0, alu_op=2'b00, alu_imm=1, mem_read=1, branch=0, mem_write=0, reg_we=1 and wb_mem=1.
- R5: Opcode 0x2B (store) gives alu_op=2'b00, alu_imm=1 and mem_write=1, with every other line 0.
- R6: Opcode 0x04 (branch-equal) gives alu_op=2'b01 and branch=1, with every other line 0.
- R7: Opcode 0x08 (add-immediate) gives dst_rd=0, alu_op=2'b11, alu_imm=1, reg_we=1 and wb_mem=0, with all memory lines 0.
- R8: Any other opcode gives all nine lines 0.
- R9: When bubble is high at a rising edge, the word entering the first stage register is all zero, whatever the opcode. That zero word then moves through the memory and write-back stages like any other word.
- R10: At most one memory line is high at a time, and the write-back source select is never high without the register write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Major opcode of the instruction in decode |
| bubble | input | 1 | Zero the control word entering the execute stage |
| ex_dst_rd | output | 1 | 1: destination is rd field; 0: rt field |
| ex_alu_op | output | 2 | ALU operation class (00 address, 01 compare, 10 function field, 11 immediate arithmetic) |
| ex_alu_imm | output | 1 | 1: ALU second operand is the sign-extended immediate |
| mem_branch | output | 1 | Branch-equal in the memory stage |
| mem_read | output | 1 | Data memory read |
| mem_write | output | 1 | Data memory write |
| wb_reg_we | output | 1 | Register file write enable |
| wb_sel_mem | output | 1 | 1: write back memory data; 0: ALU result |

## Verification
A wrong decode entry appears on the execute pins one edge after the opcode is applied. It then reappears on the memory pins one edge later and on the write-back pins one edge after that. A fault in a stage register, such as a slice crossed between stages, lost on reset or skipped on a bubble, shows up only at that stage's pins and at its exact expected delay. The bench therefore streams every opcode, with and without bubble, back to back. It checks all three groups at every cycle against the word it expects at that pipeline depth, so a fault is caught within three cycles of the instruction that exposes it.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;
  localparam int OPC_W = 6;

  typedef enum logic [1:0] {
    ALU_ADDR  = 2'b00,
    ALU_CMP   = 2'b01,
    ALU_FUNCT = 2'b10,
    ALU_IMM   = 2'b11
  } alu_sel_e;

  typedef struct packed {
    logic     dst_rd;
    alu_sel_e alu_op;
    logic     alu_imm;
  } ex_grp_t;

  typedef struct packed {
    logic br_eq;
    logic mem_rd;
    logic mem_wr;
  } mem_grp_t;

  typedef struct packed {
    logic reg_we;
    logic wb_mem;
  } wb_grp_t;

  typedef struct packed {
    ex_grp_t  ex;
    mem_grp_t mem;
    wb_grp_t  wb;
  } ctl_word_t;

  typedef struct packed {
    mem_grp_t mem;
    wb_grp_t  wb;
  } ctl_tail_t;

  localparam int WORD_W = $bits(ctl_word_t);
  localparam int TAIL_W = $bits(ctl_tail_t);
  localparam int WB_W   = $bits(wb_grp_t);

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
endpackage

// File: rtl/pipe_ctl_decode.sv
module pipe_ctl_decode
  import pipe_ctl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             bubble,
  output ctl_word_t        word
);
  ctl_word_t raw;

  always_comb begin
    raw = '0;
    unique case (opcode)
      OPC_RTYPE: begin
        raw.ex.dst_rd = 1'b1;
        raw.ex.alu_op = ALU_FUNCT;
        raw.wb.reg_we = 1'b1;
      end
      OPC_LOAD: begin
        raw.ex.alu_op  = ALU_ADDR;
        raw.ex.alu_imm = 1'b1;
        raw.mem.mem_rd = 1'b1;
        raw.wb.reg_we  = 1'b1;
        raw.wb.wb_mem  = 1'b1;
      end
      OPC_STORE: begin
        raw.ex.alu_op  = ALU_ADDR;
        raw.ex.alu_imm = 1'b1;
        raw.mem.mem_wr = 1'b1;
      end
      OPC_BEQ: begin
        raw.ex.alu_op = ALU_CMP;
        raw.mem.br_eq = 1'b1;
      end
      OPC_ADDI: begin
        raw.ex.alu_op  = ALU_IMM;
        raw.ex.alu_imm = 1'b1;
        raw.wb.reg_we  = 1'b1;
      end
      default: raw = '0;
    endcase
  end

  assign word = bubble ? ctl_word_t'('0) : raw;
endmodule

// File: rtl/pipe_ctl_stage.sv
module pipe_ctl_stage #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/pipe_ctl_top.sv
module pipe_ctl_top
  import pipe_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             bubble,
  output logic             ex_dst_rd,
  output logic [1:0]       ex_alu_op,
  output logic             ex_alu_imm,
  output logic             mem_branch,
  output logic             mem_read,
  output logic             mem_write,
  output logic             wb_reg_we,
  output logic             wb_sel_mem
);
  ctl_word_t id_word;
  ctl_word_t idex_q;
  ctl_tail_t exmem_d;
  ctl_tail_t exmem_q;
  wb_grp_t   memwb_q;

  pipe_ctl_decode u_dec (
    .opcode (opcode),
    .bubble (bubble),
    .word   (id_word)
  );

  // ID/EX: all nine lines
  pipe_ctl_stage #(.W(WORD_W)) u_idex (
    .clk (clk), .rst (rst), .d (id_word), .q (idex_q)
  );

  // EX/MEM: execute group is dropped here
  assign exmem_d.mem = idex_q.mem;
  assign exmem_d.wb  = idex_q.wb;

  pipe_ctl_stage #(.W(TAIL_W)) u_exmem (
    .clk (clk), .rst (rst), .d (exmem_d), .q (exmem_q)
  );

  // MEM/WB: only the write-back group remains
  pipe_ctl_stage #(.W(WB_W)) u_memwb (
    .clk (clk), .rst (rst), .d (exmem_q.wb), .q (memwb_q)
  );

  assign ex_dst_rd  = idex_q.ex.dst_rd;
  assign ex_alu_op  = idex_q.ex.alu_op;
  assign ex_alu_imm = idex_q.ex.alu_imm;
  assign mem_branch = exmem_q.mem.br_eq;
  assign mem_read   = exmem_q.mem.mem_rd;
  assign mem_write  = exmem_q.mem.mem_wr;
  assign wb_reg_we  = memwb_q.reg_we;
  assign wb_sel_mem = memwb_q.wb_mem;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(mem_read || mem_write || mem_branch || wb_reg_we || wb_sel_mem || ex_alu_imm));

  p_stage_advance_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mem_read == $past(idex_q.mem.mem_rd)) && (wb_reg_we == $past(exmem_q.wb.reg_we)));

  p_bubble_zero_r9: assert property (@(posedge clk) disable iff (rst)
    bubble |=> (ex_alu_op == 2'b00) && !ex_dst_rd && !ex_alu_imm);

  p_mem_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_branch, mem_read, mem_write}));

  p_wbsel_needs_we_r10: assert property (@(posedge clk) disable iff (rst)
    wb_sel_mem |-> wb_reg_we);

  p_funct_uses_rd_r3: assert property (@(posedge clk) disable iff (rst)
    (ex_alu_op == 2'b10) |-> ex_dst_rd && !ex_alu_imm);
endmodule

// File: tb/sim_pipe_ctl_top.sv
module sim_pipe_ctl_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       bubble = 1'b0;
  logic       ex_dst_rd, ex_alu_imm, mem_branch, mem_read, mem_write, wb_reg_we, wb_sel_mem;
  logic [1:0] ex_alu_op;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pipe_ctl_top u0 (
    .clk (clk), .rst (rst), .opcode (opcode), .bubble (bubble),
    .ex_dst_rd (ex_dst_rd), .ex_alu_op (ex_alu_op), .ex_alu_imm (ex_alu_imm),
    .mem_branch (mem_branch), .mem_read (mem_read), .mem_write (mem_write),
    .wb_reg_we (wb_reg_we), .wb_sel_mem (wb_sel_mem)
  );

  // expected word: {dst_rd, alu_op[1:0], alu_imm, br, rd, wr, we, wbmem}
  function automatic logic [8:0] expect_word(input logic [5:0] op, input logic bub);
    if (bub) return 9'b0;
    case (op)
      6'h00: return 9'b1_10_0_000_10; // R3
      6'h23: return 9'b0_00_1_010_11; // R4
      6'h2B: return 9'b0_00_1_001_00; // R5
      6'h04: return 9'b0_01_0_100_00; // R6
      6'h08: return 9'b0_11_1_000_10; // R7
      default: return 9'b0;           // R8
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] op, input logic bub);
    if (bub) return "R9";
    case (op)
      6'h00: return "R3";
      6'h23: return "R4";
      6'h2B: return "R5";
      6'h04: return "R6";
      6'h08: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  logic [8:0] e1 = '0, e2 = '0, e3 = '0;
  string t1 = "R1", t2 = "R1", t3 = "R1";

  // R2: each group sampled at its own depth
  task automatic check_stages();
    check({t1, " R2 ex"},  {ex_dst_rd, ex_alu_op, ex_alu_imm, 5'b0}, {e1[8:5], 5'b0});
    check({t2, " R2 mem"}, {4'b0, mem_branch, mem_read, mem_write, 2'b0}, {4'b0, e2[4:2], 2'b0});
    check({t3, " R2 wb"},  {7'b0, wb_reg_we, wb_sel_mem}, {7'b0, e3[1:0]});
    // R10
    check("R10 mem exclusive", {8'b0, ($countones({mem_branch, mem_read, mem_write}) <= 1)}, 9'd1);
    check("R10 wbsel", {8'b0, (!wb_sel_mem || wb_reg_we)}, 9'd1);
  endtask

  task automatic step(input logic [5:0] op, input logic bub, input logic r);
    opcode = op; bubble = bub; rst = r;
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      e1 = '0; e2 = '0; e3 = '0; t1 = "R1"; t2 = "R1"; t3 = "R1";
    end else begin
      e3 = e2; t3 = t2; e2 = e1; t2 = t1;
      e1 = expect_word(op, bub); t1 = tag_of(op, bub);
    end
    check_stages();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    // R1: reset holds everything at zero despite a live opcode
    for (int i = 0; i < 4; i++) step(6'h23, 1'b0, 1'b1);
    // exhaustive sweep, no bubble then with bubble
    for (int b = 0; b < 2; b++)
      for (int op = 0; op < 64; op++) step(6'(op), b[0], 1'b0);
    // interleave valid classes with bubbles
    for (int k = 0; k < 20; k++) begin
      step(6'h23, 1'b0, 1'b0);
      step(6'h2B, (k % 3) == 0, 1'b0);
      step(6'h00, 1'b0, 1'b0);
      step(6'h04, (k % 2) == 1, 1'b0);
      step(6'h08, 1'b0, 1'b0);
    end
    // R1: mid-run reset with a full pipeline
    step(6'h23, 1'b0, 1'b0);
    step(6'h00, 1'b0, 1'b0);
    step(6'h08, 1'b0, 1'b1);
    step(6'h23, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(6'h23, 1'b0, 1'b0);
    finish_up();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule